// File: doc/BRIEF.md
# Sample Period Selector with Rounding

The block turns a requested sample period, in nanoseconds, into the closest period that a set of up to four master clocks can produce. Each master clock can be divided by 1, 2, 4 or 8. The clock periods come in as a run-time table, and a separate input says how many of its entries are valid. After a one-cycle start pulse, the block latches the request, the table, the rounding mode and a configuration word.

It then clamps the request into the achievable range. Next it walks all sixteen pairs of clock and divider, one per cycle. While it walks, it tracks the tightest achievable period at or above the request and the tightest one at or below it. When the walk is complete, it picks one of the two according to the rounding mode. It returns the achieved period, the clock index and the divider shift. It also returns the configuration word with its clock field rewritten.

A controller uses the block as part of programming an acquisition clock. It pulses start, waits for done, and then writes the returned configuration word to the clock hardware.

Top module: `period_select`

## Requirements
- R1: After reset, busy_o, done_o, period_o, clk_sel_o, div_shift_o and cfg_o are all zero.
- R2: The achieved period always equals the table entry at index clk_sel_o shifted left by div_shift_o, where clk_sel_o is less than the number of valid clocks.
- R3: A request longer than entry 0 times 8 yields entry 0 with shift 3. A request shorter than the last valid entry yields that entry with shift 0.
- R4: Table entries at an index equal to or above num_clks_i take no part in the search. This holds for every value of num_clks_i from 1 to 4.
- R5: Rounding code 0 (nearest) returns the upper bound only when it is strictly closer to the clamped request. On an equal distance it returns the lower bound. Code 3 behaves as code 0.
- R6: Rounding code 1 (down) returns the largest achievable period that is not above the clamped request.
- R7: Rounding code 2 (up) returns the smallest achievable period that is not below the clamped request.
- R8: A request that one of the candidates matches exactly returns that period, in every rounding mode.
- R9: cfg_o is the word latched from cfg_i at start, with bits 6:3 cleared and then rewritten: the clock index goes into bits 4:3 and the divider shift into bits 6:5. All other bits pass through unchanged.
- R10: done_o is high for exactly one cycle, 17 rising edges after the edge that accepts start. busy_o is high from the accepting edge until done_o rises, and done_o is never high together with busy_o.
- R11: A start pulse while busy_o is high is ignored. All results hold their values from one completion until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a search; accepted only while idle |
| req_period_i | input | 32 | Requested period in ns |
| round_mode_i | input | 2 | 0 nearest, 1 down, 2 up, 3 nearest |
| num_clks_i | input | 3 | Number of valid table entries, 1 to 4 |
| clk_tab_i | input | 128 | Master clock periods; entry k at bits 32k+31:32k |
| cfg_i | input | 16 | Configuration word to be updated |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| period_o | output | 32 | Achieved period in ns |
| clk_sel_o | output | 2 | Selected master clock index |
| div_shift_o | output | 2 | Selected divider as a shift amount |
| cfg_o | output | 16 | Configuration word with clock field rewritten |

## Verification
Most requests fall between two candidates. Rounding the same request in all three modes shows whether the upper and lower bounds are tracked separately. A request exactly midway between two candidates shows whether the nearest comparison is strict. An exact match shows that both bounds can converge on the request. Requests far above and far below the range show the clamping. A three-clock table with a bait value in slot 3 that lies closer to the request shows that invalid entries are skipped. A one-clock table, a start pulse during a search and an all-ones configuration word cover the remaining cases.

// File: rtl/period_sel_pkg.sv
package period_sel_pkg;
  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_DOWN    = 2'd1,
    RND_UP      = 2'd2,
    RND_ALT     = 2'd3
  } round_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PICK = 2'd2
  } state_e;
endpackage

// File: rtl/ps_cand_gen.sv
module ps_cand_gen #(
  parameter int PW      = 32,
  parameter int CLK_N   = 4,
  parameter int SHIFT_N = 4,
  parameter int SEL_W   = $clog2(CLK_N),
  parameter int SH_W    = $clog2(SHIFT_N)
) (
  input  logic [CLK_N*PW-1:0] tab_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [SH_W-1:0]     shift_i,
  input  logic [SEL_W:0]      num_i,
  output logic [PW-1:0]       cand_o,
  output logic                vld_o
);
  logic [PW-1:0] tab_a [CLK_N];

  for (genvar k = 0; k < CLK_N; k++) begin : g_unpack
    assign tab_a[k] = tab_i[k*PW +: PW];
  end

  assign cand_o = tab_a[sel_i] << shift_i;
  assign vld_o  = {1'b0, sel_i} < num_i;
endmodule

// File: rtl/ps_bound_upd.sv
module ps_bound_upd #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] cand_i,
  input  logic          vld_i,
  input  logic [PW-1:0] req_i,
  input  logic [PW-1:0] ub_i,
  input  logic [PW-1:0] lb_i,
  output logic          take_ub_o,
  output logic          take_lb_o
);
  // strict compare against the bound: first candidate found wins on equality
  assign take_ub_o = vld_i && (cand_i < ub_i) && (cand_i >= req_i);
  assign take_lb_o = vld_i && (cand_i > lb_i) && (cand_i <= req_i);
endmodule

// File: rtl/ps_round_pick.sv
module ps_round_pick
  import period_sel_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW-1:0] ub_i,
  input  logic [PW-1:0] lb_i,
  input  logic [PW-1:0] req_i,
  input  round_e        mode_i,
  output logic          use_ub_o
);
  logic [PW-1:0] dist_up, dist_dn;

  assign dist_up = ub_i - req_i;
  assign dist_dn = req_i - lb_i;

  always_comb begin
    unique case (mode_i)
      RND_UP:   use_ub_o = 1'b1;
      RND_DOWN: use_ub_o = 1'b0;
      default:  use_ub_o = dist_up < dist_dn;
    endcase
  end
endmodule

// File: rtl/period_select.sv
module period_select
  import period_sel_pkg::*;
#(
  parameter int PW      = 32,
  parameter int CLK_N   = 4,
  parameter int SHIFT_N = 4,
  parameter int CFG_W   = 16,
  parameter int SEL_LSB = 3
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [PW-1:0]                      req_period_i,
  input  logic [1:0]                         round_mode_i,
  input  logic [$clog2(CLK_N):0]             num_clks_i,
  input  logic [CLK_N*PW-1:0]                clk_tab_i,
  input  logic [CFG_W-1:0]                   cfg_i,
  output logic                               busy_o,
  output logic                               done_o,
  output logic [PW-1:0]                      period_o,
  output logic [$clog2(CLK_N)-1:0]           clk_sel_o,
  output logic [$clog2(SHIFT_N)-1:0]         div_shift_o,
  output logic [CFG_W-1:0]                   cfg_o
);
  localparam int SEL_W  = $clog2(CLK_N);
  localparam int SH_W   = $clog2(SHIFT_N);
  localparam int SLOT_W = SEL_W + SH_W;
  localparam int SLOTS  = CLK_N * SHIFT_N;
  localparam int FLD_W  = SEL_W + SH_W;

  state_e                 st_q;
  logic [SLOT_W-1:0]      slot_q;
  logic [CLK_N*PW-1:0]    tab_q;
  logic [SEL_W:0]         num_q;
  round_e                 mode_q;
  logic [CFG_W-1:0]       cfg_q;
  logic [PW-1:0]          req_q, ub_q, lb_q;
  logic [SEL_W-1:0]       ub_sel_q, lb_sel_q;
  logic [SH_W-1:0]        ub_sh_q, lb_sh_q;

  // start-time bounds and clamp from the live inputs
  logic [PW-1:0]          tab_in_a [CLK_N];
  logic [SEL_W-1:0]       lb_init_sel;
  logic [PW-1:0]          ub_init, lb_init, req_clamp;

  for (genvar k = 0; k < CLK_N; k++) begin : g_tab_in
    assign tab_in_a[k] = clk_tab_i[k*PW +: PW];
  end

  assign lb_init_sel = SEL_W'(num_clks_i - 1'b1);
  assign ub_init     = tab_in_a[0] << SH_W'(SHIFT_N - 1);
  assign lb_init     = tab_in_a[lb_init_sel];

  always_comb begin
    req_clamp = req_period_i;
    if (req_clamp > ub_init) req_clamp = ub_init;
    if (req_clamp < lb_init) req_clamp = lb_init;
  end

  // candidate for the current slot: divider shift outer, clock index inner
  logic [SEL_W-1:0] slot_sel;
  logic [SH_W-1:0]  slot_sh;
  logic [PW-1:0]    cand;
  logic             cand_vld, take_ub, take_lb, use_ub;

  assign slot_sel = slot_q[SEL_W-1:0];
  assign slot_sh  = slot_q[SLOT_W-1:SEL_W];

  ps_cand_gen #(
    .PW(PW), .CLK_N(CLK_N), .SHIFT_N(SHIFT_N), .SEL_W(SEL_W), .SH_W(SH_W)
  ) i_cand (
    .tab_i   (tab_q),
    .sel_i   (slot_sel),
    .shift_i (slot_sh),
    .num_i   (num_q),
    .cand_o  (cand),
    .vld_o   (cand_vld)
  );

  ps_bound_upd #(.PW(PW)) i_bound (
    .cand_i    (cand),
    .vld_i     (cand_vld),
    .req_i     (req_q),
    .ub_i      (ub_q),
    .lb_i      (lb_q),
    .take_ub_o (take_ub),
    .take_lb_o (take_lb)
  );

  ps_round_pick #(.PW(PW)) i_pick (
    .ub_i     (ub_q),
    .lb_i     (lb_q),
    .req_i    (req_q),
    .mode_i   (mode_q),
    .use_ub_o (use_ub)
  );

  logic [SEL_W-1:0] pick_sel;
  logic [SH_W-1:0]  pick_sh;
  logic [CFG_W-1:0] cfg_new;

  assign pick_sel = use_ub ? ub_sel_q : lb_sel_q;
  assign pick_sh  = use_ub ? ub_sh_q  : lb_sh_q;

  always_comb begin
    cfg_new = cfg_q;
    cfg_new[SEL_LSB +: FLD_W] = '0;
    cfg_new[SEL_LSB +: SEL_W] = pick_sel;
    cfg_new[SEL_LSB + SEL_W +: SH_W] = pick_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      slot_q   <= '0;
      tab_q    <= '0;
      num_q    <= '0;
      mode_q   <= RND_NEAREST;
      cfg_q    <= '0;
      req_q    <= '0;
      ub_q     <= '0;
      lb_q     <= '0;
      ub_sel_q <= '0;
      lb_sel_q <= '0;
      ub_sh_q  <= '0;
      lb_sh_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q     <= ST_SCAN;
            slot_q   <= '0;
            tab_q    <= clk_tab_i;
            num_q    <= num_clks_i;
            mode_q   <= round_e'(round_mode_i);
            cfg_q    <= cfg_i;
            req_q    <= req_clamp;
            ub_q     <= ub_init;
            ub_sel_q <= '0;
            ub_sh_q  <= SH_W'(SHIFT_N - 1);
            lb_q     <= lb_init;
            lb_sel_q <= lb_init_sel;
            lb_sh_q  <= '0;
          end
        end
        ST_SCAN: begin
          if (take_ub) begin
            ub_q     <= cand;
            ub_sel_q <= slot_sel;
            ub_sh_q  <= slot_sh;
          end
          if (take_lb) begin
            lb_q     <= cand;
            lb_sel_q <= slot_sel;
            lb_sh_q  <= slot_sh;
          end
          slot_q <= slot_q + 1'b1;
          if (slot_q == SLOT_W'(SLOTS - 1)) st_q <= ST_PICK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      period_o    <= '0;
      clk_sel_o   <= '0;
      div_shift_o <= '0;
      cfg_o       <= '0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_PICK) begin
        done_o      <= 1'b1;
        period_o    <= use_ub ? ub_q : lb_q;
        clk_sel_o   <= pick_sel;
        div_shift_o <= pick_sh;
        cfg_o       <= cfg_new;
      end
    end
  end

  assign busy_o = st_q != ST_IDLE;
endmodule

// File: rtl/period_select_chk.sv
module period_select_chk #(
  parameter int PW      = 32,
  parameter int SEL_W   = 2,
  parameter int SH_W    = 2,
  parameter int CFG_W   = 16,
  parameter int SEL_LSB = 3,
  parameter int LAT     = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [PW-1:0]    period_o,
  input logic [SEL_W-1:0] clk_sel_o,
  input logic [SH_W-1:0]  div_shift_o,
  input logic [CFG_W-1:0] cfg_o
);
  localparam int LAT_W = $clog2(LAT + 1) + 1;

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (start_i && !busy_o) lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == LAT_W'(LAT)); // R10

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(period_o) && $stable(clk_sel_o)
                               && $stable(div_shift_o) && $stable(cfg_o))); // R11

  AST_CFG_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cfg_o[SEL_LSB +: SEL_W + SH_W] == {div_shift_o, clk_sel_o}); // R9
endmodule

bind period_select period_select_chk #(
  .PW(PW), .SEL_W($clog2(CLK_N)), .SH_W($clog2(SHIFT_N)),
  .CFG_W(CFG_W), .SEL_LSB(SEL_LSB), .LAT(CLK_N * SHIFT_N + 1)
) i_period_select_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .period_o    (period_o),
  .clk_sel_o   (clk_sel_o),
  .div_shift_o (div_shift_o),
  .cfg_o       (cfg_o)
);

// File: tb/test_period_select.sv
`timescale 1ns/1ps
module test_period_select;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  req = '0;
  logic [1:0]   mode = '0;
  logic [2:0]   num = 3'd4;
  logic [127:0] tab = '0;
  logic [15:0]  cfg = '0;
  logic         busy, done;
  logic [31:0]  period;
  logic [1:0]   sel, shf;
  logic [15:0]  cfg_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  period_select i_period_select (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_period_i(req),
    .round_mode_i(mode), .num_clks_i(num), .clk_tab_i(tab), .cfg_i(cfg),
    .busy_o(busy), .done_o(done), .period_o(period), .clk_sel_o(sel),
    .div_shift_o(shf), .cfg_o(cfg_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic void ref_sel(input int unsigned t[4], input int n, input int unsigned r,
                                  input int m, output int unsigned p, output int s, output int h);
    int unsigned ub, lb, rq;
    int us, uh, ls, lh;
    ub = t[0] << 3; us = 0; uh = 3;
    lb = t[n-1];    ls = n - 1; lh = 0;
    rq = r;
    if (rq > ub) rq = ub;
    if (rq < lb) rq = lb;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < n; j++) begin
        int unsigned c;
        c = t[j] << i;
        if (c < ub && c >= rq) begin ub = c; us = j; uh = i; end
        if (c > lb && c <= rq) begin lb = c; ls = j; lh = i; end
      end
    end
    if (m == 2 || (m != 1 && (ub - rq) < (rq - lb))) begin p = ub; s = us; h = uh; end
    else begin p = lb; s = ls; h = lh; end
  endfunction

  task automatic wait_done(input string tag, input int exp_lat);
    int n = 0;
    bit seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      n++;
      chk({tag, " R10 busy/done exclusive"}, {31'd0, busy & done}, 32'd0);
      if (done) seen = 1;
    end
    chk({tag, " R10 done latency"}, n, exp_lat);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input string tag, input int unsigned t[4], input int n,
                          input int unsigned r, input int m, input logic [15:0] c);
    int unsigned ep;
    int es, eh;
    logic [15:0] ecfg;
    ref_sel(t, n, r, m, ep, es, eh);
    tab = {t[3], t[2], t[1], t[0]};
    num = 3'(n); req = r; mode = 2'(m); cfg = c;
    pulse_start();
    chk({tag, " R10 busy after start"}, {31'd0, busy}, 32'd1);
    wait_done(tag, 17);
    chk({tag, " period"}, period, ep);
    chk({tag, " R2 clk_sel"}, {30'd0, sel}, es);
    chk({tag, " R2 div_shift"}, {30'd0, shf}, eh);
    chk({tag, " R2 period from table"}, period, t[sel] << shf);
    ecfg = c;
    ecfg[6:3] = {2'(eh), 2'(es)};
    chk({tag, " R9 cfg"}, {16'd0, cfg_out}, {16'd0, ecfg});
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, {31'd0, done}, 32'd0);
    chk({tag, " R11 period held"}, period, ep);
  endtask

  int unsigned tab_a[4] = '{31250, 22676, 20833, 19531};
  int unsigned tab_b[4] = '{62500, 50000, 41667, 45000};

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 period", period, 0);
    chk("R1 sel/shift", {28'd0, sel, shf}, 0);
    chk("R1 cfg", {16'd0, cfg_out}, 0);
  endtask

  task automatic t_modes();
    run_case("R5 nearest 40000", tab_a, 4, 40000, 0, 16'h0000);
    chk("R5 nearest picks 39062", period, 39062);
    run_case("R6 down 40000", tab_a, 4, 40000, 1, 16'h0000);
    chk("R6 down value", period, 39062);
    run_case("R7 up 40000", tab_a, 4, 40000, 2, 16'h0000);
    chk("R7 up value", period, 41666);
    run_case("R5 nearest 41500", tab_a, 4, 41500, 0, 16'h0000);
    chk("R5 nearest picks upper", period, 41666);
    run_case("R5 tie picks lower", tab_a, 4, 40364, 0, 16'h0000);
    chk("R5 tie value", period, 39062);
    run_case("R5 code 3 as nearest", tab_a, 4, 41500, 3, 16'h0000);
    chk("R5 code 3 value", period, 41666);
  endtask

  task automatic t_exact();
    run_case("R8 exact nearest", tab_a, 4, 45352, 0, 16'h0000);
    chk("R8 nearest value", period, 45352);
    run_case("R8 exact up", tab_a, 4, 83332, 2, 16'h0000);
    chk("R8 up value", period, 83332);
    run_case("R8 exact down", tab_a, 4, 156248, 1, 16'h0000);
    chk("R8 down value", period, 156248);
  endtask

  task automatic t_clamp();
    run_case("R3 clamp high", tab_a, 4, 1000000, 1, 16'h0000);
    chk("R3 high value", period, 250000);
    run_case("R3 clamp low", tab_a, 4, 100, 2, 16'h0000);
    chk("R3 low value", period, 19531);
    chk("R3 low index", {28'd0, sel, shf}, {28'd0, 2'd3, 2'd0});
  endtask

  task automatic t_skip();
    run_case("R4 up skips slot3", tab_b, 3, 45000, 2, 16'h0000);
    chk("R4 up value", period, 50000);
    run_case("R4 down skips slot3", tab_b, 3, 46000, 1, 16'h0000);
    chk("R4 down value", period, 41667);
    run_case("R4 one clock", tab_a, 1, 70000, 0, 16'h0000);
    chk("R4 one clock value", period, 62500);
    chk("R4 one clock sel", {30'd0, sel}, 0);
  endtask

  task automatic t_cfg();
    run_case("R9 cfg passthrough", tab_a, 4, 90000, 0, 16'hFFFF);
    chk("R9 other bits", {16'd0, cfg_out & 16'hFF87}, 32'h0000FF87);
  endtask

  task automatic t_ignore();
    int unsigned ep;
    int es, eh;
    ref_sel(tab_a, 4, 40000, 2, ep, es, eh);
    tab = {tab_a[3], tab_a[2], tab_a[1], tab_a[0]};
    num = 3'd4; req = 40000; mode = 2'd2; cfg = 16'h0000;
    pulse_start();
    repeat (4) @(negedge clk);
    req = 160000; mode = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11 start ignored", 12);
    chk("R11 ignored start period", period, ep);
    chk("R11 ignored start mode", period, 41666);
    repeat (3) @(negedge clk);
    chk("R11 hold after done", period, ep);
    chk("R11 busy stays low", {31'd0, busy}, 0);
  endtask

  initial begin
    #(4 * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_modes();
    t_exact();
    t_clamp();
    t_skip();
    t_cfg();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule